// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block guards a processor against runaway software. A free-running counter advances on a count-enable tick that comes from a slow, separately powered oscillator. If software lets the counter reach the end of its selected period, the block asks the chip to reset. Software keeps the timer from expiring by writing a fixed key byte to an arming register. That write clears the counter.

Two byte-wide registers sit on a plain register bus. The first is a configuration register. It may be written only once after reset, and it sets the period and an optional permanent shutdown. The second is the arming register, which takes the key. Every write carries a flag that marks it as either a whole-byte store or a single-bit read-modify-write. Certain accesses break the protocol: a repeated configuration write, a wrong key, or a bit-wise write to the arming register. Each of these raises the same reset request as an expiry. If the slow oscillator is halted when such an access happens, the request waits until the oscillator runs again.

A static strap input selects one of two behaviours. In the locked behaviour the counter never stops and keeps running through the low-power states. In the stoppable behaviour, software may shut the timer down for good, and the counter freezes while the processor sleeps. The reset request is a one-cycle pulse. A sticky cause field records why it fired.

Top module: `guard_wdog`

## Requirements
- R1: After reset, rst_req_o is 0, cause_o is 0, and the configuration register reads 0x67. That value is bits 7:5 = 011, shutdown bit 4 = 0 and period select 2:0 = 7.
- R2: The first whole-byte write to the configuration register (addr_i = 0) loads the period select from bits 2:0. Bits 7:5 of the write are discarded, and the register always reads them back as 011.
- R3: Any whole-byte write to the configuration register after the first raises a reset pulse and sets cause_o bit 1. The stored value stays unchanged.
- R4: A bit-wise write (bit_op_i = 1) to the configuration register is ignored. It raises no pulse, leaves the value unchanged, and does not use up the single permitted write.
- R5: A whole-byte write of 0xAC to the arming register (addr_i = 1) clears the counter to zero.
- R6: A whole-byte write of any value other than 0xAC to the arming register raises a reset pulse and sets cause_o bit 2.
- R7: A bit-wise write to the arming register raises a reset pulse and sets cause_o bit 2, whatever its data.
- R8: A read of the arming register returns 0x9A.
- R9: With select N, the counter expires after 2^(N+10) counted ticks. This raises a reset pulse in the cycle after the last counted tick and sets cause_o bit 0. Cycles with tick_i = 0 are not counted.
- R10: An illegal access made while osc_run_i = 0 raises no pulse until osc_run_i returns to 1. The pulse then appears in the next cycle with the saved cause.
- R11: With stoppable_i = 1, a first configuration write with bit 4 set stops the timer for good. It then never expires, later accesses of any kind raise no pulse, and bit 4 reads back as 1. With stoppable_i = 0, bit 4 is ignored and reads back as 0.
- R12: With stoppable_i = 0, the counter keeps counting while halt_i or stop_i is high, and it can expire there.
- R13: With stoppable_i = 1, the counter holds its value while halt_i or stop_i is high. It resumes from that value with the same period afterwards.
- R14: Every reset request is a single registered pulse that carries at least one cause bit. The cause bits are sticky until rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable from the slow oscillator, synchronous to clk |
| osc_run_i | input | 1 | Slow oscillator is running |
| stoppable_i | input | 1 | Static strap: 1 allows software shutdown and sleep pausing |
| halt_i | input | 1 | Processor is in the HALT state |
| stop_i | input | 1 | Processor is in the STOP state |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 1 | 0 = configuration register, 1 = arming register |
| bit_op_i | input | 1 | Write is a single-bit read-modify-write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the same cycle as rd_en_i, 0 otherwise |
| rst_req_o | output | 1 | One-cycle internal reset request |
| cause_o | output | 3 | Sticky cause: bit 0 expiry, bit 1 repeated configuration write, bit 2 arming fault |

## Verification
The assertions take several things about the inputs for granted. Every input is synchronous to clk. A read and a write never share a cycle. stoppable_i changes only while rst_n is low. tick_i is meaningful only while osc_run_i is high. The stimulus respects all of this: the strap is chosen inside the reset task, bus strobes are produced one at a time by the access tasks or the random loop, and the oscillator, tick and sleep inputs are toggled only at the falling clock edge. The register interface is a plain strobe bus with no back-pressure, so every access completes in its own cycle.

// File: rtl/guard_wdog_pkg.sv
package guard_wdog_pkg;
  localparam int DW = 8;
  localparam logic [DW-1:0] ARM_KEY  = 8'hAC;
  localparam logic [DW-1:0] KEY_ECHO = 8'h9A;
  localparam logic [2:0]    MODE_TOP = 3'b011;
  localparam int SHUT_BIT = 4;

  localparam int CZ_W      = 3;
  localparam int CZ_OVF    = 0;
  localparam int CZ_REMODE = 1;
  localparam int CZ_KEY    = 2;

  typedef logic [CZ_W-1:0] cause_t;

  typedef enum logic {
    SEL_MODE = 1'b0,
    SEL_ARM  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/gw_access.sv
module gw_access
  import guard_wdog_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter logic [SEL_W-1:0] SEL_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stoppable_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic             addr_i,
  input  logic             bit_op_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             halted_o,
  output logic             clr_o,
  output cause_t           bad_o
);
  logic             written_q;
  logic             halted_q;
  logic [SEL_W-1:0] sel_q;
  logic             mode_byte;
  logic             arm_wr;
  logic             arm_ok;
  logic [DW-1:0]    mode_view;
  logic             wdata_unused;

  assign wdata_unused = ^wdata_i;

  always_comb begin
    mode_byte = wr_en_i && !halted_q && (reg_sel_e'(addr_i) == SEL_MODE) && !bit_op_i;
    arm_wr    = wr_en_i && !halted_q && (reg_sel_e'(addr_i) == SEL_ARM);
    arm_ok    = arm_wr && !bit_op_i && (wdata_i == ARM_KEY);
    bad_o            = '0;
    bad_o[CZ_REMODE] = mode_byte && written_q;
    bad_o[CZ_KEY]    = arm_wr && !arm_ok;
  end

  assign clr_o = arm_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      written_q <= 1'b0;
      halted_q  <= 1'b0;
      sel_q     <= SEL_RST;
    end else if (mode_byte && !written_q) begin
      written_q <= 1'b1;
      sel_q     <= wdata_i[SEL_W-1:0];
      if (stoppable_i && wdata_i[SHUT_BIT]) halted_q <= 1'b1;
    end
  end

  always_comb begin
    mode_view               = '0;
    mode_view[DW-1 -: 3]    = MODE_TOP;
    mode_view[SHUT_BIT]     = halted_q;
    mode_view[SEL_W-1:0]    = sel_q;
  end

  always_comb begin
    if (!rd_en_i)                             rdata_o = '0;
    else if (reg_sel_e'(addr_i) == SEL_ARM)   rdata_o = KEY_ECHO;
    else                                      rdata_o = mode_view;
  end

  assign sel_o    = sel_q;
  assign halted_o = halted_q;
endmodule

// File: rtl/gw_counter.sv
module gw_counter #(
  parameter int CNT_W    = 18,
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ovf_o
);
  localparam int SPAN = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val [SPAN];
  logic             at_end;
  logic             step;

  for (genvar g = 0; g < SPAN; g++) begin : g_last
    assign last_val[g] = CNT_W'((64'd1 << (BASE_EXP + g)) - 64'd1);
  end

  assign at_end = (cnt_q >= last_val[sel_i]);
  assign step   = run_i && tick_i && !clr_i;
  assign ovf_o  = step && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step)    cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/gw_reset_gen.sv
module gw_reset_gen
  import guard_wdog_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   halted_i,
  input  logic   osc_i,
  input  cause_t bad_i,
  input  logic   ovf_i,
  output logic   req_o,
  output cause_t cause_o
);
  cause_t pend_q;
  cause_t cause_q;
  cause_t fire;
  logic   req_q;

  always_comb begin
    fire = '0;
    if (!halted_i) begin
      if (osc_i) fire = bad_i | pend_q;
      fire[CZ_OVF] = fire[CZ_OVF] | ovf_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      cause_q <= '0;
      pend_q  <= '0;
    end else begin
      req_q   <= |fire;
      cause_q <= cause_q | fire;
      if (halted_i || osc_i) pend_q <= '0;
      else                   pend_q <= pend_q | bad_i;
    end
  end

  assign req_o   = req_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/guard_wdog.sv
module guard_wdog
  import guard_wdog_pkg::*;
#(
  parameter int CNT_W    = 18,
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          osc_run_i,
  input  logic          stoppable_i,
  input  logic          halt_i,
  input  logic          stop_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic          addr_i,
  input  logic          bit_op_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          rst_req_o,
  output logic [2:0]    cause_o
);
  logic [SEL_W-1:0] sel;
  logic             halted;
  logic             clr;
  logic             ovf;
  logic             run;
  cause_t           bad;

  assign run = !halted && osc_run_i && !(stoppable_i && (halt_i || stop_i));

  gw_access #(.SEL_W(SEL_W)) u_access (
    .clk        (clk),
    .rst_n      (rst_n),
    .stoppable_i(stoppable_i),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .bit_op_i   (bit_op_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .sel_o      (sel),
    .halted_o   (halted),
    .clr_o      (clr),
    .bad_o      (bad)
  );

  gw_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W), .BASE_EXP(BASE_EXP)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (run),
    .tick_i(tick_i),
    .clr_i (clr),
    .sel_i (sel),
    .ovf_o (ovf)
  );

  gw_reset_gen u_rgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .halted_i(halted),
    .osc_i   (osc_run_i),
    .bad_i   (bad),
    .ovf_i   (ovf),
    .req_o   (rst_req_o),
    .cause_o (cause_o)
  );
endmodule

// File: rtl/guard_wdog_chk.sv
module guard_wdog_chk
  import guard_wdog_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       osc_run_i,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic       addr_i,
  input logic [7:0] rdata_o,
  input logic       rst_req_o,
  input logic [2:0] cause_o
);
  // R14
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o != 3'b000) |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

  // R14
  req_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (cause_o != 3'b000));

  // R8
  key_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i && !wr_en_i) |-> (rdata_o == KEY_ECHO));

  // R2
  mode_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !addr_i && !wr_en_i) |-> (rdata_o[7:5] == MODE_TOP));

  // R10
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run_i |=> !rst_req_o);

  // R11
  shut_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !addr_i && !wr_en_i && rdata_o[SHUT_BIT]) |=> !rst_req_o);

  // R9
  expiry_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_o[CZ_OVF]) |-> $past(tick_i));
endmodule

bind guard_wdog guard_wdog_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_i   (tick_i),
  .osc_run_i(osc_run_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .rst_req_o(rst_req_o),
  .cause_o  (cause_o)
);

// File: tb/guard_wdog_tb_top.sv
module guard_wdog_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, osc = 1'b1, stp_cfg = 1'b0, halt = 1'b0, stop = 1'b0;
  logic wr = 1'b0, rd = 1'b0, addr = 1'b0, bop = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata_o;
  logic       rst_req_o;
  logic [2:0] cause_o;

  int n_chk = 0;
  int n_fail = 0;
  int wd_cnt = 0;

  always #10 clk = ~clk;

  guard_wdog dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .osc_run_i(osc),
    .stoppable_i(stp_cfg), .halt_i(halt), .stop_i(stop),
    .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .bit_op_i(bop),
    .wdata_i(wd), .rdata_o(rdata_o), .rst_req_o(rst_req_o), .cause_o(cause_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Behavioural reference built from the requirements
  int m_cnt, m_n;
  bit m_wr, m_dead;
  logic [2:0] m_pend, e_cause;
  logic e_req;

  function automatic logic [7:0] mode_exp();
    return {3'b011, m_dead, 1'b0, 3'(m_n)};
  endfunction

  always @(posedge clk) begin
    logic [2:0] bad, fb;
    logic clr, run, ovf;
    int lim, n_next;
    bit d_next, w_next;
    if (!rst_n) begin
      m_cnt = 0; m_n = 7; m_wr = 0; m_dead = 0; m_pend = 0; e_req = 0; e_cause = 0;
    end else begin
      bad = 0; clr = 0; n_next = m_n; d_next = m_dead; w_next = m_wr;
      run = !m_dead && osc && !(stp_cfg && (halt || stop));
      if (!m_dead && wr) begin
        if (!addr) begin
          if (!bop) begin
            if (m_wr) bad[1] = 1;
            else begin
              w_next = 1; n_next = int'(wd[2:0]);
              if (stp_cfg && wd[4]) d_next = 1;
            end
          end
        end else if (bop || wd != 8'hAC) bad[2] = 1;
        else clr = 1;
      end
      lim = 1 << (m_n + 10);
      ovf = 0;
      if (clr) m_cnt = 0;
      else if (run && tick) begin
        if (m_cnt >= lim - 1) begin m_cnt = 0; ovf = 1; end
        else m_cnt++;
      end
      fb = 0;
      if (!m_dead) begin
        if (osc) fb = bad | m_pend;
        if (ovf) fb[0] = 1;
      end
      if (m_dead || osc) m_pend = 0; else m_pend = m_pend | bad;
      e_req = |fb;
      e_cause = e_cause | fb;
      m_n = n_next; m_dead = d_next; m_wr = w_next;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R14 pulse vs reference", rst_req_o, e_req);
      chk("R14 cause vs reference", cause_o, e_cause);
    end
  end

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 190000) begin
      n_fail++;
      $display("FAIL R14 watchdog: actual %0d cycles expected fewer", wd_cnt);
      finish_up();
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic cfg);
    rst_n = 0; wr = 0; rd = 0; bop = 0; halt = 0; stop = 0; osc = 1;
    stp_cfg = cfg;
    cyc(2);
    rst_n = 1;
  endtask

  task automatic wr_acc(input logic a, input logic [7:0] d, input logic b);
    wr = 1; addr = a; wd = d; bop = b;
    cyc(1);
    wr = 0; bop = 0;
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string tag);
    rd = 1; addr = a;
    #1;
    chk(tag, rdata_o, exp);
    rd = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    tick = 1;
    do_reset(0);
    // R1 reset state
    chk("R1 req after reset", rst_req_o, 0);
    chk("R1 cause after reset", cause_o, 0);
    rd_chk(0, 8'h67, "R1 mode reset value");
    rd_chk(1, 8'h9A, "R8 key echo");
    // R4 bit write to mode ignored
    wr_acc(0, 8'h60, 1);
    rd_chk(0, 8'h67, "R4 bit write ignored");
    chk("R4 no pulse", rst_req_o, 0);
    // R2 / R11 first write, bit4 ignored when locked
    wr_acc(0, 8'hF8, 0);
    rd_chk(0, 8'h60, "R2 R11 first write readback");
    // R5 key clears, R9 expiry after 1024 ticks
    wr_acc(1, 8'hAC, 0);
    chk("R5 no pulse on key", rst_req_o, 0);
    cyc(1023);
    chk("R5 no expiry before period", rst_req_o, 0);
    cyc(1);
    chk("R9 expiry pulse", rst_req_o, 1);
    chk("R9 expiry cause", cause_o, 3'b001);
    cyc(1);
    chk("R14 pulse one cycle", rst_req_o, 0);
    // R3 repeated mode write
    wr_acc(0, 8'h61, 0);
    chk("R3 repeat write pulse", rst_req_o, 1);
    chk("R3 R14 cause sticky", cause_o, 3'b011);
    rd_chk(0, 8'h60, "R3 value unchanged");

    // R6 bad key
    do_reset(0);
    wr_acc(1, 8'h5A, 0);
    chk("R6 bad key pulse", rst_req_o, 1);
    chk("R6 bad key cause", cause_o, 3'b100);
    // R7 bit write to arming register
    do_reset(0);
    wr_acc(1, 8'hAC, 1);
    chk("R7 bit write pulse", rst_req_o, 1);
    chk("R7 bit write cause", cause_o, 3'b100);
    // R10 pending while oscillator stopped
    do_reset(0);
    osc = 0;
    wr_acc(1, 8'h00, 0);
    chk("R10 held while stopped", rst_req_o, 0);
    cyc(5);
    chk("R10 still held", rst_req_o, 0);
    chk("R10 no cause yet", cause_o, 0);
    osc = 1;
    cyc(1);
    chk("R10 released pulse", rst_req_o, 1);
    chk("R10 released cause", cause_o, 3'b100);

    // R11 permanent shutdown
    do_reset(1);
    wr_acc(0, 8'h70, 0);
    rd_chk(0, 8'h70, "R11 shutdown readback");
    cyc(3000);
    chk("R11 no expiry", cause_o, 0);
    wr_acc(1, 8'h11, 0);
    chk("R11 bad key ignored", rst_req_o, 0);
    wr_acc(0, 8'h60, 0);
    chk("R11 rewrite ignored", rst_req_o, 0);
    rd_chk(0, 8'h70, "R11 stays stopped");
    chk("R11 cause clear", cause_o, 0);

    // R13 pause in sleep, keep count
    do_reset(1);
    wr_acc(0, 8'h60, 0);
    wr_acc(1, 8'hAC, 0);
    cyc(500);
    halt = 1;
    cyc(1000);
    halt = 0; stop = 1;
    cyc(1000);
    stop = 0;
    chk("R13 no expiry while asleep", cause_o, 0);
    cyc(523);
    chk("R13 count kept", rst_req_o, 0);
    cyc(1);
    chk("R13 resumed expiry", rst_req_o, 1);

    // R12 locked config counts in STOP; R9 idle ticks not counted
    do_reset(0);
    wr_acc(0, 8'h60, 0);
    cyc(1000);
    tick = 0;
    stop = 1;
    wr_acc(1, 8'hAC, 0);
    cyc(300);
    chk("R9 idle ticks not counted", rst_req_o, 0);
    tick = 1;
    cyc(1023);
    chk("R12 before expiry", rst_req_o, 0);
    cyc(1);
    chk("R12 expiry in stop", rst_req_o, 1);
    chk("R12 cause", cause_o, 3'b001);
    stop = 0;

    // Random phase against the reference
    for (int ep = 0; ep < 6; ep++) begin
      do_reset(1'($urandom % 2));
      for (int c = 0; c < 3000; c++) begin
        tick = ($urandom % 4) != 0;
        if ($urandom % 60 == 0) osc = !osc;
        if ($urandom % 40 == 0) halt = !halt;
        if ($urandom % 40 == 0) stop = !stop;
        rd = 0;
        if ($urandom % 150 == 0) begin
          wr = 1; addr = 1'($urandom % 2); bop = ($urandom % 5) == 0;
          if (addr) wd = (($urandom % 4) != 0) ? 8'hAC : 8'($urandom);
          else      wd = 8'($urandom);
        end else begin
          wr = 0; bop = 0;
          if ($urandom % 20 == 0) begin
            rd = 1; addr = 1'($urandom % 2);
            #1;
            chk(addr ? "R8 random read" : "R2 random read", rdata_o,
                addr ? 8'h9A : mode_exp());
          end
        end
        cyc(1);
      end
      wr = 0; rd = 0; bop = 0;
    end

    finish_up();
  end
endmodule